// File: doc/BRIEF.md
# Write-Only Configuration Register Slave for a Clock Generator

This block receives configuration for a clock generator over a two-wire serial bus (clock line and data line, wired-AND). It is write-only: a bus master sends one block-write frame and the block commits it to eight 8-bit control registers. Both bus lines are oversampled by the fast system clock. Each line passes through a synchronizer and a glitch filter. After that, bus clock edges and start/stop conditions are detected. The block acknowledges each accepted byte by pulling the data line low during the acknowledge bit.

A frame opens with a start condition and an address byte, which must be 1101_0010. Two bytes follow that are kept only to hold the byte positions. Up to eight data bytes come next, each committed as soon as its last bit arrives. The register contents are presented as decoded control outputs:

- a run/stop bit for each clock output;
- the frequency-select source and the software select code;
- a request to put all clock outputs into high impedance.

Top module: `cfgWriteSlave`

## Requirements
- R1: The first byte after a start is the address. Only 1101_0010 (0xD2) is accepted. For any other address the block pulls no acknowledge for the rest of the frame and changes no register.
- R2: With a matching address, the second and third bytes are acknowledged and then dropped. Their values reach no register.
- R3: Bytes 4 to 11 of a frame land in registers 0 to 7 in that order. Every byte is received most significant bit first.
- R4: After reset, the registers hold 0x00, 0x0B, 0x5F, 0x37, 0x00, 0x13, 0x00, 0x00. Every run bit is 1, and the select, source and three-state outputs are 0.
- R5: Register 0 bit 3 is the frequency-select source (0 = pins, 1 = software). Register 0 bits 6:4 are the 3-bit software select code.
- R6: The three-state request is high only when register 0 bits 1:0 equal 11. The codes 00, 01 and 10 leave it low.
- R7: In each run bit, 1 lets the output run and 0 holds it low. The bit map is:
  - register 1: bit 0 is CPU0, bit 1 is CPU1, bit 3 is SDRAM12;
  - register 2: bits 0 to 4 are PCI1 to PCI5, bit 6 is the free-running PCI clock;
  - register 3: bits 0, 1 and 2 are SDRAM banks 0, 1 and 2, bit 4 is the 24 MHz clock, bit 5 is the 48 MHz clock;
  - register 5: bit 0 is REF0, bit 1 is REF1, bit 4 is the interrupt-controller clock.
- R8: For each accepted byte, the slave starts holding the data line low at the bus-clock falling edge after the eighth bit. It releases the line at the next falling edge.
- R9: Bytes after the eleventh are still acknowledged but are discarded. No register changes.
- R10: A stop or start condition in the middle of a byte abandons that byte. Bytes already completed stay committed. A start begins a new frame at the address byte.
- R11: Registers change only in the cycle a complete data byte is committed.
- R12: A pulse on a bus line shorter than the filter length (3 system-clock samples) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | 1 pulls the data line low (acknowledge) |
| swFreqSel | output | 1 | Frequency-select source, 1 = software code |
| freqCode | output | 3 | Software frequency select code |
| triStateReq | output | 1 | Request to float all clock outputs |
| cpuRun | output | 2 | Run bits for CPU0 and CPU1 |
| sdram12Run | output | 1 | Run bit for SDRAM12 |
| pciRun | output | 5 | Run bits for PCI1 to PCI5 |
| pciFixRun | output | 1 | Run bit for the free-running PCI clock |
| sdramBankRun | output | 3 | Run bits for SDRAM banks 0 to 2 |
| sioRun | output | 1 | Run bit for the 24 MHz clock |
| usbRun | output | 1 | Run bit for the 48 MHz clock |
| refRun | output | 2 | Run bits for REF0 and REF1 |
| ioapicRun | output | 1 | Run bit for the interrupt-controller clock |

## Verification
Several rules are checked on every cycle:

- the acknowledge only starts or ends at a filtered bus-clock falling edge, or ends at an abort;
- a wrong address never leads to an acknowledge;
- registers stay frozen outside a commit;
- a filtered level only follows a synchronized sample that has settled.

Other behaviour can only be shown by the scenarios. These cover the register map and its defaults, the ordering of bits and bytes, the dropping of header and surplus bytes, aborted bytes, and rejected glitches. All of them are checked through the decoded outputs after whole bus frames.

// File: rtl/cfgSlavePkg.sv
package cfgSlavePkg;
  localparam int NUM_REGS   = 8;
  localparam int HDR_BYTES  = 3;
  localparam int FRAME_LEN  = HDR_BYTES + NUM_REGS;
  localparam int IDX_W      = $clog2(FRAME_LEN + 1);
  localparam int REG_IDX_W  = $clog2(NUM_REGS);
  localparam logic [7:0] ADDR_BYTE = 8'hD2;

  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_ACKWAIT, ST_ACKHOLD} busState_t;

  typedef struct packed {
    logic                 shiftEn;
    logic                 commitEn;
    logic [REG_IDX_W-1:0] regIdx;
  } strobe_t;

  function automatic logic [7:0] regDefault(input int idx);
    case (idx)
      1:       return 8'h0B;
      2:       return 8'h5F;
      3:       return 8'h37;
      5:       return 8'h13;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgBusFilter.sv
module cfgBusFilter #(
  parameter int SYNC = 2,
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  localparam int LINES = 2;  // 0 = clock line, 1 = data line

  logic [LINES-1:0] rawIn;
  logic [SYNC-1:0]  syncQ [LINES];
  logic [FILT-1:0]  histQ [LINES];
  logic [LINES-1:0] lvlQ, prevQ;

  assign rawIn = {sdaIn, sclIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        syncQ[i] <= '1;
        histQ[i] <= '1;
      end
      lvlQ  <= '1;
      prevQ <= '1;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        syncQ[i] <= {syncQ[i][SYNC-2:0], rawIn[i]};
        histQ[i] <= {histQ[i][FILT-2:0], syncQ[i][SYNC-1]};
        if (&histQ[i])       lvlQ[i] <= 1'b1;
        else if (~|histQ[i]) lvlQ[i] <= 1'b0;
      end
      prevQ <= lvlQ;
    end
  end

  assign sdaLvl  = lvlQ[1];
  assign sclRise = lvlQ[0] & ~prevQ[0];
  assign sclFall = ~lvlQ[0] & prevQ[0];
  assign startEv = lvlQ[0] & prevQ[0] & prevQ[1] & ~lvlQ[1];
  assign stopEv  = lvlQ[0] & prevQ[0] & ~prevQ[1] & lvlQ[1];

  // R12: a filtered level only takes a value the synchronizer has settled on
  assert_filter_agree_R12: assert property (@(posedge clk) disable iff (!rstN)
    $changed(lvlQ[0]) |-> ($past(syncQ[0][SYNC-1], 2) == lvlQ[0]));
endmodule

// File: rtl/cfgBusCtrl.sv
module cfgBusCtrl
  import cfgSlavePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic [7:0] rxByte,
  output strobe_t    stb,
  output logic       sdaDriveLow
);
  busState_t        state;
  logic [2:0]       bitCnt;
  logic [IDX_W-1:0] byteIdx;
  logic             lastBit, addrBad;

  assign lastBit = (state == ST_BITS) && sclRise && (bitCnt == 3'd7);
  assign addrBad = (byteIdx == '0) && (rxByte != ADDR_BYTE);

  always_comb begin
    stb.shiftEn  = (state == ST_BITS) && sclRise;
    stb.commitEn = lastBit && (byteIdx >= IDX_W'(HDR_BYTES))
                           && (byteIdx <  IDX_W'(FRAME_LEN));
    stb.regIdx   = REG_IDX_W'(byteIdx - IDX_W'(HDR_BYTES));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      byteIdx     <= '0;
      sdaDriveLow <= 1'b0;
    end else if (startEv) begin
      state       <= ST_BITS;
      bitCnt      <= '0;
      byteIdx     <= '0;
      sdaDriveLow <= 1'b0;
    end else if (stopEv) begin
      state       <= ST_IDLE;
      sdaDriveLow <= 1'b0;
    end else begin
      case (state)
        ST_BITS: if (sclRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            if (addrBad) state <= ST_IDLE;
            else begin
              state <= ST_ACKWAIT;
              if (byteIdx != IDX_W'(FRAME_LEN)) byteIdx <= byteIdx + 1'b1;
            end
          end
        end
        ST_ACKWAIT: if (sclFall) begin
          sdaDriveLow <= 1'b1;
          state       <= ST_ACKHOLD;
        end
        ST_ACKHOLD: if (sclFall) begin
          sdaDriveLow <= 1'b0;
          bitCnt      <= '0;
          state       <= ST_BITS;
        end
        default: ;
      endcase
    end
  end

  // R8: acknowledge begins on a filtered clock fall
  assert_ack_on_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> $past(sclFall));
  // R8: acknowledge ends on a clock fall or an abort
  assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDriveLow) |-> $past(sclFall || stopEv || startEv));
  // R1: a foreign address is never acknowledged
  assert_nack_bad_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (lastBit && addrBad && !startEv && !stopEv) |=> !sdaDriveLow);
endmodule

// File: rtl/cfgDatapath.sv
module cfgDatapath
  import cfgSlavePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaLvl,
  input  strobe_t    stb,
  output logic [7:0] rxByte,
  output logic       swFreqSel,
  output logic [2:0] freqCode,
  output logic       triStateReq,
  output logic [1:0] cpuRun,
  output logic       sdram12Run,
  output logic [4:0] pciRun,
  output logic       pciFixRun,
  output logic [2:0] sdramBankRun,
  output logic       sioRun,
  output logic       usbRun,
  output logic [1:0] refRun,
  output logic       ioapicRun
);
  logic [6:0]                shiftQ;
  logic [NUM_REGS-1:0][7:0]  regQ;

  assign rxByte = {shiftQ, sdaLvl};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= regDefault(i);
    end else begin
      if (stb.shiftEn)  shiftQ <= {shiftQ[5:0], sdaLvl};
      if (stb.commitEn) regQ[stb.regIdx] <= rxByte;
    end
  end

  assign swFreqSel    = regQ[0][3];
  assign freqCode     = regQ[0][6:4];
  assign triStateReq  = &regQ[0][1:0];
  assign cpuRun       = regQ[1][1:0];
  assign sdram12Run   = regQ[1][3];
  assign pciRun       = regQ[2][4:0];
  assign pciFixRun    = regQ[2][6];
  assign sdramBankRun = regQ[3][2:0];
  assign sioRun       = regQ[3][4];
  assign usbRun       = regQ[3][5];
  assign refRun       = regQ[5][1:0];
  assign ioapicRun    = regQ[5][4];

  // R11: register file frozen unless the controller commits a byte
  assert_regs_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commitEn |=> $stable(regQ));
endmodule

// File: rtl/cfgWriteSlave.sv
module cfgWriteSlave
  import cfgSlavePkg::*;
#(
  parameter int SYNC = 2,
  parameter int FILT = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDriveLow,
  output logic       swFreqSel,
  output logic [2:0] freqCode,
  output logic       triStateReq,
  output logic [1:0] cpuRun,
  output logic       sdram12Run,
  output logic [4:0] pciRun,
  output logic       pciFixRun,
  output logic [2:0] sdramBankRun,
  output logic       sioRun,
  output logic       usbRun,
  output logic [1:0] refRun,
  output logic       ioapicRun
);
  logic       sdaLvl, sclRise, sclFall, startEv, stopEv;
  logic [7:0] rxByte;
  strobe_t    stb;

  cfgBusFilter #(.SYNC(SYNC), .FILT(FILT)) u_filter (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv));

  cfgBusCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .rxByte(rxByte),
    .stb(stb), .sdaDriveLow(sdaDriveLow));

  cfgDatapath u_dpath (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .stb(stb), .rxByte(rxByte),
    .swFreqSel(swFreqSel), .freqCode(freqCode), .triStateReq(triStateReq),
    .cpuRun(cpuRun), .sdram12Run(sdram12Run), .pciRun(pciRun),
    .pciFixRun(pciFixRun), .sdramBankRun(sdramBankRun), .sioRun(sioRun),
    .usbRun(usbRun), .refRun(refRun), .ioapicRun(ioapicRun));
endmodule

// File: tb/cfgWriteSlave_bench.sv
module cfgWriteSlave_bench;
  localparam int Q = 20;  // quarter bus-bit in system clocks

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, sdaBus;
  logic sdaDriveLow, swFreqSel, triStateReq, sdram12Run, pciFixRun;
  logic sioRun, usbRun, ioapicRun;
  logic [2:0] freqCode, sdramBankRun;
  logic [1:0] cpuRun, refRun;
  logic [4:0] pciRun;
  logic [21:0] snap;

  always #4 clk = ~clk;  // 125 MHz
  assign sdaBus = sdaM & ~sdaDriveLow;
  assign snap = {triStateReq, swFreqSel, freqCode, cpuRun, sdram12Run, pciRun,
                 pciFixRun, usbRun, sioRun, sdramBankRun, ioapicRun, refRun};

  cfgWriteSlave u_cfgWriteSlave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .swFreqSel(swFreqSel), .freqCode(freqCode),
    .triStateReq(triStateReq), .cpuRun(cpuRun), .sdram12Run(sdram12Run),
    .pciRun(pciRun), .pciFixRun(pciFixRun), .sdramBankRun(sdramBankRun),
    .sioRun(sioRun), .usbRun(usbRun), .refRun(refRun), .ioapicRun(ioapicRun));

  typedef struct { bit isAck; logic [21:0] exp; string tag; } item_t;
  item_t sbQ[$];
  int checks = 0, fails = 0;
  bit done = 0, glitchOn = 0;
  logic [7:0] mdl [8];

  function automatic logic [21:0] expSnap();
    return {&mdl[0][1:0], mdl[0][3], mdl[0][6:4], mdl[1][1:0], mdl[1][3],
            mdl[2][4:0], mdl[2][6], mdl[3][5], mdl[3][4], mdl[3][2:0],
            mdl[5][4], mdl[5][1:0]};
  endfunction

  task automatic pushItem(bit isAck, logic [21:0] exp, string tag);
    item_t it;
    it.isAck = isAck; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // monitor: pops expected items and compares with what the block shows
  initial forever begin
    @(negedge clk); #1;
    while (sbQ.size() > 0) begin
      item_t it;
      logic [21:0] act;
      it  = sbQ.pop_front();
      act = it.isAck ? {21'b0, sdaDriveLow} : snap;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(Q); sclM = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q); sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(Q); sclM = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(Q);
  endtask

  task automatic sendBit(logic b);
    sdaM = b;
    if (glitchOn) begin
      waitClk(Q/2); sclM = 1'b1; waitClk(2); sclM = 1'b0; waitClk(Q/2 - 2);
    end else waitClk(Q);
    sclM = 1'b1; waitClk(2*Q); sclM = 1'b0; waitClk(Q);
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) sendBit(b[i]);
  endtask

  task automatic ackBit(bit expAck, string tag);
    sdaM = 1'b1; waitClk(Q);
    pushItem(1'b1, {21'b0, expAck}, tag);
    sclM = 1'b1; waitClk(2*Q); sclM = 1'b0; waitClk(Q);
  endtask

  // frame: byte i sits at fr[8*(n-1-i) +: 8]
  task automatic sendFrame(logic [127:0] fr, int n, bit withStop);
    bit good;
    good = (fr[8*(n-1) +: 8] == 8'hD2);
    busStart();
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = fr[8*(n-1-i) +: 8];
      sendBits(b, 8);
      if (i == 0)       ackBit(good, "R1 address ack");
      else if (i < 3)   ackBit(good, "R2 header ack");
      else if (i < 11)  ackBit(good, "R8 data ack");
      else              ackBit(good, "R9 surplus ack");
      if (good && i >= 3 && i < 11) mdl[i-3] = b;
    end
    if (withStop) busStop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    mdl[0] = 8'h00; mdl[1] = 8'h0B; mdl[2] = 8'h5F; mdl[3] = 8'h37;
    mdl[4] = 8'h00; mdl[5] = 8'h13; mdl[6] = 8'h00; mdl[7] = 8'h00;
    waitClk(5); rstN = 1'b1; waitClk(10);
    pushItem(1'b0, expSnap(), "R4 reset defaults");
    waitClk(2);

    // R3 R5 R6 R7: full frame, header values must not land anywhere (R2)
    sendFrame({8'hD2, 8'hA5, 8'h3C, 8'h5B, 8'h02, 8'h2A, 8'h15,
               8'hFF, 8'h01, 8'h00, 8'h00}, 11, 1'b1);
    waitClk(Q);
    pushItem(1'b0, expSnap(), "R3 R5 R6 R7 map after frame");

    // R1: foreign addresses leave everything unchanged
    sendFrame({8'hD0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 6, 1'b1);
    waitClk(Q);
    pushItem(1'b0, expSnap(), "R1 wrong address 0xD0");
    sendFrame({8'hD3, 8'h00, 8'h00, 8'hFF, 8'hFF}, 5, 1'b1);
    waitClk(Q);
    pushItem(1'b0, expSnap(), "R1 wrong address 0xD3");

    // R9: two surplus bytes acknowledged and dropped
    sendFrame({8'hD2, 8'h00, 8'h00, 8'h13, 8'h0B, 8'h5F, 8'h37,
               8'h00, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00}, 13, 1'b1);
    waitClk(Q);
    pushItem(1'b0, expSnap(), "R9 surplus bytes discarded");

    // R10: stop in the middle of data byte 1
    sendFrame({8'hD2, 8'h00, 8'h00, 8'h22}, 4, 1'b0);
    sendBits(8'h00, 4);
    busStop();
    waitClk(Q);
    pushItem(1'b0, expSnap(), "R10 stop mid-byte, R6 code 10");

    // R10: start in the middle of data byte 0, then a fresh frame
    sendFrame({8'hD2, 8'h00, 8'h00}, 3, 1'b0);
    sendBits(8'hFF, 3);
    sendFrame({8'hD2, 8'h00, 8'h00, 8'h61}, 4, 1'b1);
    waitClk(Q);
    pushItem(1'b0, expSnap(), "R10 restart mid-byte, R6 code 01");

    // R12: short clock-line pulses inside every bit must be ignored
    glitchOn = 1;
    sendFrame({8'hD2, 8'h00, 8'h00, 8'h38, 8'h01}, 5, 1'b1);
    glitchOn = 0;
    waitClk(Q);
    pushItem(1'b0, expSnap(), "R12 glitches rejected");

    waitClk(10);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule